// File: doc/BRIEF.md
# Dual-Port Lock Flag Bank

This block holds eight one-bit lock flags that two symmetric ports, A and B, use to coordinate software access to a shared resource. Both ports run on one clock. On each port, an access counts only when the lock-select input is high and the memory-enable input is low. A write with data bit 0 equal to 0 requests the addressed flag. A write with data bit 0 equal to 1 releases it. A read returns the caller's view of the flag, replicated across the whole data byte: 8'h00 means "this port holds the flag", and 8'hFF means it does not.

Each flag is a small state machine with three states:

- `LK_FREE`: the flag is unowned.
- `LK_HELD_A`: port A owns the flag.
- `LK_HELD_B`: port B owns the flag.

The machine also keeps one pending-request bit for each port. The transitions are:

- **grant** (`LK_FREE` to `LK_HELD_x`): the flag goes to a requester. When both ports request in the same cycle, port A wins and B's request becomes pending.
- **queue** (stays in `LK_HELD_x`): the non-owner's request is remembered as pending.
- **withdraw** (stays in `LK_HELD_x`): the non-owner writes 1, which clears its pending request.
- **handoff** (`LK_HELD_x` to `LK_HELD_y`): the owner releases while the other port has a pending request, or is requesting in that same cycle.
- **free** (`LK_HELD_x` to `LK_FREE`): the owner releases and nothing is waiting.

Software takes a lock by writing 0 and then reading back. Only a read value of 0 means the lock was obtained.

Top module: `dp_lock_bank`

## Requirements
- R1: After reset every flag is `LK_FREE` with no pending requests, and both read-data outputs are 8'hFF.
- R2: An access happens only when sem_en=1 and ram_en=0. While ram_en=1, writes change no flag and reads leave the read data unchanged.
- R3: A write of bit0=0 to a free flag gives that port ownership. A read issued in cycle N returns the state as it stood before edge N, and the result appears on rdata after that edge. The owner reads 8'h00.
- R4: The port that does not own a held flag reads it as 8'hFF.
- R5: If both ports write bit0=0 to the same free flag in one cycle, port A becomes owner and B's request is held pending.
- R6: When the owner writes bit0=1 while the other port has a pending request (or requests in that same cycle), ownership moves straight to the other port.
- R7: When the owner writes bit0=1 with no request waiting, the flag becomes free and both ports then read 8'hFF.
- R8: A write of bit0=1 by the non-owner withdraws its pending request, so a later release by the owner frees the flag.
- R9: The eight flags, selected by addr[2:0], are independent of one another.
- R10: Only wdata bit 0 is significant, and read data is always 8'h00 or 8'hFF.
- R11: A request by the current owner has no effect. A release of a free flag has no effect.
- R12: rdata keeps its value in every cycle without a valid read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Active-low synchronous reset |
| a_sem_en | input | 1 | Port A lock-select |
| a_ram_en | input | 1 | Port A memory enable; blocks lock access when high |
| a_wr | input | 1 | Port A write (1) / read (0) |
| a_addr | input | 3 | Port A flag index |
| a_wdata | input | 8 | Port A write data; bit 0 used |
| a_rdata | output | 8 | Port A registered read data |
| b_sem_en | input | 1 | Port B lock-select |
| b_ram_en | input | 1 | Port B memory enable; blocks lock access when high |
| b_wr | input | 1 | Port B write (1) / read (0) |
| b_addr | input | 3 | Port B flag index |
| b_wdata | input | 8 | Port B write data; bit 0 used |
| b_rdata | output | 8 | Port B registered read data |

## Verification
Two kinds of event can land in the same cycle on one flag. The first is a pair of grants, when both ports request a free flag together. The second is a release by the owner together with a request from the other port, which must produce a handoff in one step. The bench provokes both on purpose, and it also issues many random cycles on a narrow address range so that such collisions recur. A behavioural model of owners and pending bits predicts both read-data bytes, and the bench compares them with the outputs after every edge.

// File: rtl/lk_pkg.sv
package lk_pkg;
    localparam int LK_NUM  = 8;
    localparam int LK_DW   = 8;

    typedef enum logic [1:0] {
        LK_FREE   = 2'd0,
        LK_HELD_A = 2'd1,
        LK_HELD_B = 2'd2
    } lk_state_e;
endpackage

// File: rtl/lk_port_decode.sv
module lk_port_decode #(
    parameter int N  = 8,
    parameter int DW = 8,
    localparam int AW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          sem_en,
    input  logic          ram_en,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [N-1:0]  req_vec,
    output logic [N-1:0]  rel_vec,
    output logic          rd_stb,
    output logic [AW-1:0] rd_addr
);
    logic access;
    logic wr_hit;
    logic unused_hi;

    assign access    = sem_en & ~ram_en;
    assign wr_hit    = access & wr;
    assign rd_stb    = access & ~wr;
    assign rd_addr   = addr;
    assign unused_hi = ^wdata[DW-1:1];

    for (genvar i = 0; i < N; i++) begin : g_sel
        logic hit;
        assign hit        = wr_hit & (addr == AW'(i));
        assign req_vec[i] = hit & ~wdata[0];
        assign rel_vec[i] = hit &  wdata[0];
    end

    always_comb begin
        assert (!((|req_vec) && (|rel_vec)));
    end
endmodule

// File: rtl/lk_flag.sv
module lk_flag
    import lk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_a,
    input  logic rel_a,
    input  logic req_b,
    input  logic rel_b,
    output logic held_a,
    output logic held_b
);
    lk_state_e st_q, st_d;
    logic      pend_a_q, pend_a_d;
    logic      pend_b_q, pend_b_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= LK_FREE;
            pend_a_q <= 1'b0;
            pend_b_q <= 1'b0;
        end else begin
            st_q     <= st_d;
            pend_a_q <= pend_a_d;
            pend_b_q <= pend_b_d;
        end
    end

    always_comb begin
        st_d     = st_q;
        pend_a_d = pend_a_q;
        pend_b_d = pend_b_q;
        unique case (st_q)
            LK_FREE: begin
                pend_a_d = 1'b0;
                pend_b_d = 1'b0;
                if (req_a) begin
                    st_d     = LK_HELD_A;
                    pend_b_d = req_b;
                end else if (req_b) begin
                    st_d = LK_HELD_B;
                end
            end
            LK_HELD_A: begin
                pend_a_d = 1'b0;
                if (rel_a) begin
                    if ((pend_b_q && !rel_b) || req_b) begin
                        st_d = LK_HELD_B;
                    end else begin
                        st_d = LK_FREE;
                    end
                    pend_b_d = 1'b0;
                end else if (req_b) begin
                    pend_b_d = 1'b1;
                end else if (rel_b) begin
                    pend_b_d = 1'b0;
                end
            end
            LK_HELD_B: begin
                pend_b_d = 1'b0;
                if (rel_b) begin
                    if ((pend_a_q && !rel_a) || req_a) begin
                        st_d = LK_HELD_A;
                    end else begin
                        st_d = LK_FREE;
                    end
                    pend_a_d = 1'b0;
                end else if (req_a) begin
                    pend_a_d = 1'b1;
                end else if (rel_a) begin
                    pend_a_d = 1'b0;
                end
            end
            default: begin
                st_d     = LK_FREE;
                pend_a_d = 1'b0;
                pend_b_d = 1'b0;
            end
        endcase
    end

    always_comb begin
        held_a = 1'b0;
        held_b = 1'b0;
        unique case (st_q)
            LK_HELD_A: held_a = 1'b1;
            LK_HELD_B: held_b = 1'b1;
            default: ;
        endcase
    end

    AST_FREE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == LK_FREE) |-> (!pend_a_q && !pend_b_q)); // R7
    AST_TIE_A_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == LK_FREE && req_a && req_b) |=> (st_q == LK_HELD_A && pend_b_q)); // R5
    AST_HANDOFF_B: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == LK_HELD_A && rel_a && pend_b_q && !rel_b) |=> (st_q == LK_HELD_B)); // R6
    AST_HANDOFF_A: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == LK_HELD_B && rel_b && pend_a_q && !rel_a) |=> (st_q == LK_HELD_A)); // R6
    AST_KEEP_A: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == LK_HELD_A && !rel_a) |=> (st_q == LK_HELD_A)); // R11
    AST_KEEP_B: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == LK_HELD_B && !rel_b) |=> (st_q == LK_HELD_B)); // R11
    AST_FREE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == LK_FREE && !req_a && !req_b) |=> (st_q == LK_FREE)); // R11
endmodule

// File: rtl/lk_readback.sv
module lk_readback #(
    parameter int N  = 8,
    parameter int DW = 8,
    localparam int AW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_stb,
    input  logic [AW-1:0] rd_addr,
    input  logic [N-1:0]  own_vec,
    output logic [DW-1:0] rdata
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '1;
        end else if (rd_stb) begin
            rdata <= {DW{~own_vec[rd_addr]}};
        end
    end

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> $stable(rdata)); // R12
    AST_RD_REPL: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata == '0) || (rdata == '1)); // R10
    AST_RD_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && own_vec[rd_addr]) |=> (rdata == '0)); // R3
endmodule

// File: rtl/dp_lock_bank.sv
module dp_lock_bank
    import lk_pkg::*;
#(
    parameter int N  = LK_NUM,
    parameter int DW = LK_DW,
    localparam int AW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          a_sem_en,
    input  logic          a_ram_en,
    input  logic          a_wr,
    input  logic [AW-1:0] a_addr,
    input  logic [DW-1:0] a_wdata,
    output logic [DW-1:0] a_rdata,
    input  logic          b_sem_en,
    input  logic          b_ram_en,
    input  logic          b_wr,
    input  logic [AW-1:0] b_addr,
    input  logic [DW-1:0] b_wdata,
    output logic [DW-1:0] b_rdata
);
    logic [N-1:0]  a_req, a_rel, b_req, b_rel;
    logic [N-1:0]  a_own, b_own;
    logic          a_rd, b_rd;
    logic [AW-1:0] a_raddr, b_raddr;

    lk_port_decode #(.N(N), .DW(DW)) u_dec_a (
        .sem_en (a_sem_en), .ram_en (a_ram_en), .wr (a_wr),
        .addr (a_addr), .wdata (a_wdata),
        .req_vec (a_req), .rel_vec (a_rel),
        .rd_stb (a_rd), .rd_addr (a_raddr)
    );

    lk_port_decode #(.N(N), .DW(DW)) u_dec_b (
        .sem_en (b_sem_en), .ram_en (b_ram_en), .wr (b_wr),
        .addr (b_addr), .wdata (b_wdata),
        .req_vec (b_req), .rel_vec (b_rel),
        .rd_stb (b_rd), .rd_addr (b_raddr)
    );

    for (genvar k = 0; k < N; k++) begin : g_flag
        lk_flag u_flag (
            .clk (clk), .rst_n (rst_n),
            .req_a (a_req[k]), .rel_a (a_rel[k]),
            .req_b (b_req[k]), .rel_b (b_rel[k]),
            .held_a (a_own[k]), .held_b (b_own[k])
        );
    end

    lk_readback #(.N(N), .DW(DW)) u_rb_a (
        .clk (clk), .rst_n (rst_n), .rd_stb (a_rd), .rd_addr (a_raddr),
        .own_vec (a_own), .rdata (a_rdata)
    );

    lk_readback #(.N(N), .DW(DW)) u_rb_b (
        .clk (clk), .rst_n (rst_n), .rd_stb (b_rd), .rd_addr (b_raddr),
        .own_vec (b_own), .rdata (b_rdata)
    );

    AST_NO_BOTH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (a_rd && b_rd && a_raddr == b_raddr) |=> !(a_rdata == '0 && b_rdata == '0)); // R5
    AST_BLOCKED_A: assert property (@(posedge clk) disable iff (!rst_n)
        (a_ram_en && !b_rd) |=> ($stable(a_rdata) && $stable(b_rdata))); // R2
endmodule

// File: tb/dp_lock_bank_tb_top.sv
module dp_lock_bank_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       a_sem_en = 0, a_ram_en = 0, a_wr = 0;
    logic [2:0] a_addr = 0;
    logic [7:0] a_wdata = 0;
    logic [7:0] a_rdata;
    logic       b_sem_en = 0, b_ram_en = 0, b_wr = 0;
    logic [2:0] b_addr = 0;
    logic [7:0] b_wdata = 0;
    logic [7:0] b_rdata;

    int tests = 0;
    int fails = 0;

    // model: 0 free, 1 held by A, 2 held by B
    int         own [8];
    bit         pa [8];
    bit         pb [8];
    logic [7:0] exp_a = 8'hFF;
    logic [7:0] exp_b = 8'hFF;

    always #2 clk = ~clk;

    dp_lock_bank dut_i (
        .clk (clk), .rst_n (rst_n),
        .a_sem_en (a_sem_en), .a_ram_en (a_ram_en), .a_wr (a_wr),
        .a_addr (a_addr), .a_wdata (a_wdata), .a_rdata (a_rdata),
        .b_sem_en (b_sem_en), .b_ram_en (b_ram_en), .b_wr (b_wr),
        .b_addr (b_addr), .b_wdata (b_wdata), .b_rdata (b_rdata)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] expv, input string side);
        tests++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s port %s: actual %02h expected %02h", tag, side, act, expv);
        end
    endtask

    // op codes: 0 idle, 1 read, 2 write, 3 write with ram_en, 4 read with ram_en
    task automatic model_step(input int opa, input int ada, input logic [7:0] da,
                              input int opb, input int adb, input logic [7:0] db);
        if (opa == 1) exp_a = (own[ada] == 1) ? 8'h00 : 8'hFF;
        if (opb == 1) exp_b = (own[adb] == 2) ? 8'h00 : 8'hFF;
        for (int k = 0; k < 8; k++) begin
            bit rqa, rla, rqb, rlb;
            rqa = (opa == 2) && (ada == k) && !da[0];
            rla = (opa == 2) && (ada == k) &&  da[0];
            rqb = (opb == 2) && (adb == k) && !db[0];
            rlb = (opb == 2) && (adb == k) &&  db[0];
            if (own[k] == 0) begin
                if (rqa) begin own[k] = 1; pb[k] = rqb; end
                else if (rqb) own[k] = 2;
            end else if (own[k] == 1) begin
                if (rla) begin
                    own[k] = ((pb[k] && !rlb) || rqb) ? 2 : 0;
                    pb[k] = 0;
                end else if (rqb) pb[k] = 1;
                else if (rlb) pb[k] = 0;
            end else begin
                if (rlb) begin
                    own[k] = ((pa[k] && !rla) || rqa) ? 1 : 0;
                    pa[k] = 0;
                end else if (rqa) pa[k] = 1;
                else if (rla) pa[k] = 0;
            end
        end
    endtask

    task automatic cyc(input int opa, input int ada, input logic [7:0] da,
                       input int opb, input int adb, input logic [7:0] db,
                       input string tag);
        @(negedge clk);
        a_sem_en = (opa != 0); a_ram_en = (opa >= 3); a_wr = (opa == 2 || opa == 3);
        a_addr = 3'(ada); a_wdata = da;
        b_sem_en = (opb != 0); b_ram_en = (opb >= 3); b_wr = (opb == 2 || opb == 3);
        b_addr = 3'(adb); b_wdata = db;
        @(posedge clk);
        model_step(opa, ada, da, opb, adb, db);
        #1;
        check(tag, a_rdata, exp_a, "A");
        check(tag, b_rdata, exp_b, "B");
    endtask

    task automatic rd_both(input int ad, input string tag);
        cyc(1, ad, 8'h00, 1, ad, 8'h00, tag);
    endtask

    initial begin
        #(4 * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int k = 0; k < 8; k++) begin own[k] = 0; pa[k] = 0; pb[k] = 0; end
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset", a_rdata, 8'hFF, "A");
        check("R1 reset", b_rdata, 8'hFF, "B");
        @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < 8; k++) rd_both(k, "R1 free");

        // R3 / R4: grant and views
        cyc(2, 2, 8'h00, 0, 0, 8'h00, "R3 grant");
        rd_both(2, "R3 R4 views");
        // R6: queued request then handoff
        cyc(0, 0, 8'h00, 2, 2, 8'h00, "R6 queue");
        rd_both(2, "R6 before");
        cyc(2, 2, 8'h01, 0, 0, 8'h00, "R6 handoff");
        rd_both(2, "R6 after");
        // R7: free
        cyc(0, 0, 8'h00, 2, 2, 8'h01, "R7 release");
        rd_both(2, "R7 free");
        // R5: tie
        cyc(2, 5, 8'h00, 2, 5, 8'h00, "R5 tie");
        rd_both(5, "R5 A wins");
        cyc(2, 5, 8'h01, 0, 0, 8'h00, "R6 tie handoff");
        rd_both(5, "R6 B owns");
        // R6: release and request in one cycle
        cyc(2, 5, 8'h00, 2, 5, 8'h01, "R6 same cycle");
        rd_both(5, "R6 A owns");
        cyc(2, 5, 8'h01, 0, 0, 8'h00, "R7 release 5");
        rd_both(5, "R7 free 5");
        // R8: withdraw
        cyc(2, 1, 8'h00, 0, 0, 8'h00, "R8 take");
        cyc(0, 0, 8'h00, 2, 1, 8'h00, "R8 queue");
        cyc(0, 0, 8'h00, 2, 1, 8'h01, "R8 withdraw");
        cyc(2, 1, 8'h01, 0, 0, 8'h00, "R8 release");
        rd_both(1, "R8 free");
        // R2: ram_en blocks
        cyc(3, 4, 8'h00, 3, 4, 8'h00, "R2 blocked write");
        rd_both(4, "R2 still free");
        cyc(2, 4, 8'h00, 0, 0, 8'h00, "R2 take");
        cyc(4, 4, 8'h00, 4, 4, 8'h00, "R2 blocked read");
        cyc(1, 4, 8'h00, 4, 4, 8'h00, "R2 A reads");
        cyc(4, 4, 8'h00, 1, 4, 8'h00, "R2 B reads");
        cyc(2, 4, 8'h01, 0, 0, 8'h00, "R2 release");
        // R9: independence
        for (int k = 0; k < 8; k++)
            cyc((k % 2 == 0) ? 2 : 0, k, 8'h00, (k % 2 == 1) ? 2 : 0, k, 8'h00, "R9 split");
        for (int k = 0; k < 8; k++) rd_both(k, "R9 views");
        for (int k = 0; k < 8; k++)
            cyc((k % 2 == 0) ? 2 : 0, k, 8'h01, (k % 2 == 1) ? 2 : 0, k, 8'h01, "R9 drop");
        // R10: upper bits ignored
        cyc(2, 3, 8'hFE, 0, 0, 8'h00, "R10 request FE");
        rd_both(3, "R10 held");
        cyc(2, 3, 8'h01, 2, 6, 8'h80, "R10 release 01");
        rd_both(3, "R10 free");
        rd_both(6, "R10 B 80");
        cyc(0, 0, 8'h00, 2, 6, 8'hFF, "R10 release FF");
        rd_both(6, "R10 free 6");
        // R11: re-request and free release
        cyc(2, 7, 8'h00, 0, 0, 8'h00, "R11 take");
        cyc(2, 7, 8'h00, 2, 0, 8'h01, "R11 re-request");
        rd_both(7, "R11 still A");
        rd_both(0, "R11 free kept");
        cyc(2, 7, 8'h01, 0, 0, 8'h00, "R11 release");
        rd_both(7, "R11 free");
        // R12: hold across idle
        repeat (3) cyc(0, 0, 8'h00, 0, 0, 8'h00, "R12 hold");
        // random contention on narrow range
        for (int n = 0; n < 600; n++) begin
            int oa, ob;
            oa = int'($urandom_range(0, 4));
            ob = int'($urandom_range(0, 4));
            cyc(oa, int'($urandom_range(0, 1)), 8'($urandom),
                ob, int'($urandom_range(0, 1)), 8'($urandom), "R5 R6 random");
        end
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule